// File: doc/BRIEF.md
# Multithreaded Banked Control Register File

This block holds the control registers of a core that runs several thread contexts grouped into virtual processors. Each implemented register address belongs to one of three bank classes: one copy for the whole core, one copy per thread context, or one copy per virtual processor. Every access carries a thread ID. For thread-banked registers that ID picks the copy directly. For virtual-processor-banked registers, the copy is picked by the virtual-processor number held in the accessing thread's binding register.

On reset, the file loads its multithreading configuration. This includes the continuation and threading-present flags, the highest-thread and highest-virtual-processor counts, and a per-thread binding. Only thread 0 starts active, and every thread is marked allocatable.

A write with effect schedules a deferred evaluation of every thread's halt and activation state. Further writes with effect fold into the evaluation already scheduled. When the evaluation runs, it walks the threads one per cycle and publishes a new run-enable vector together with a one-cycle done pulse. Plain writes and all reads go straight to storage and never schedule anything.

Top module: `mt_cregs`

## Requirements
- R1: An address is register number times 8 plus select. Addresses with no implemented register read as zero and ignore writes. Address 3 is such a hole, and the multithreading configuration register sits at address 2.
- R2: Thread-banked registers (thread status 17, binding 18, halt 20, thread context 21, processor status 96, linked address 136) keep a separate copy per thread ID.
- R3: Virtual-processor-banked registers (control 9, config0 10, config1 11, yield mask 12, schedule 13, exception base 121) are selected by binding bits [3:0] of the accessing thread. A number of N_VPES or more reads zero and drops writes.
- R4: Core-wide registers (1, 2, 128 to 131, scratch 250) have a single copy, seen identically from every thread.
- R5: After reset, bit 31 of addresses 128, 129 and 130 is 1, bit 2 of address 131 is 1, and bit 1 of config0 (address 10) of virtual processor 0 is 1. Every other bit of these registers is 0.
- R6: After reset, address 2 holds bit 15 = 1, bits [13:10] = N_VPES-1 and bits [7:0] = N_THREADS-1.
- R7: After reset, each thread's binding bits [28:21] equal its ID, every halt register (bit 0 = halt) is 0, and thread status bit 7 is 1 for all threads. Thread status bit 15 (activated) is 1 for thread 0 only.
- R8: run_en resets to thread 0 only. An evaluation sets bit t to (activated AND NOT halt) for each t up to min(address 2 bits [7:0], N_THREADS-1), and leaves the higher bits unchanged.
- R9: A write with effect while idle raises eval_pending. eval_done and the new run_en appear EVAL_DELAY + thread count cycles after the write edge.
- R10: A write with effect while eval_pending is high schedules no further evaluation, so exactly one done pulse results.
- R11: Writes without effect never raise eval_pending or eval_done and never change run_en.
- R12: eval_done is high for exactly one cycle per evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_effect | input | 1 | Write also schedules a thread-state evaluation |
| wr_addr | input | 8 | Write register address (number*8+select) |
| wr_tid | input | $clog2(N_THREADS) | Thread issuing the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read register address |
| rd_tid | input | $clog2(N_THREADS) | Thread issuing the read |
| rd_data | output | 32 | Combinational read data |
| run_en | output | N_THREADS | Per-thread run enable |
| eval_done | output | 1 | One-cycle pulse at the end of an evaluation |
| eval_pending | output | 1 | An evaluation is scheduled or running |

## Verification
A wrong bank selection shows up at rd_data as soon as one thread reads a copy that another thread wrote. The binding register is therefore rewritten to steer threads onto different virtual processors, including one that does not exist. A broken pending flag or delay counter appears as a done pulse that is missing, doubled or shifted. The scoreboard pins each pulse to an exact cycle. A wrong walk range or halt/activated decode leaves a wrong bit in run_en in the same cycle that eval_done rises.

// File: rtl/mtcr_pkg.sv
`timescale 1ns/1ps
package mtcr_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int SLOT_W = 3;
    localparam int VPF_W  = 4;

    typedef enum logic [1:0] {BK_NONE, BK_SHARED, BK_THREAD, BK_VPROC} bank_e;
    typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_WALK} phase_e;

    typedef struct packed {
        logic              hit;
        bank_e             bank;
        logic [SLOT_W-1:0] slot;
    } reg_loc_t;

    localparam int NUM_TC_SLOTS = 6;
    localparam int NUM_VP_SLOTS = 6;
    localparam int NUM_SH_SLOTS = 7;

    localparam int TS_STATUS = 0, TS_BIND = 1, TS_HALT = 2, TS_CTX = 3, TS_PSTAT = 4, TS_LLADDR = 5;
    localparam int VS_CTL = 0, VS_CFG0 = 1, VS_CFG1 = 2, VS_YMASK = 3, VS_SCHED = 4, VS_XBASE = 5;
    localparam int SS_MTCTL = 0, SS_MTCFG = 1, SS_CFGA = 2, SS_CFGB = 3, SS_CFGC = 4, SS_CFGD = 5, SS_SCRATCH = 6;

    // register number * 8 + select
    localparam logic [ADDR_W-1:0] A_MTCTL   = 8'd1;
    localparam logic [ADDR_W-1:0] A_MTCFG   = 8'd2;
    localparam logic [ADDR_W-1:0] A_VCTL    = 8'd9;
    localparam logic [ADDR_W-1:0] A_VCFG0   = 8'd10;
    localparam logic [ADDR_W-1:0] A_VCFG1   = 8'd11;
    localparam logic [ADDR_W-1:0] A_YMASK   = 8'd12;
    localparam logic [ADDR_W-1:0] A_VSCHED  = 8'd13;
    localparam logic [ADDR_W-1:0] A_TSTAT   = 8'd17;
    localparam logic [ADDR_W-1:0] A_TBIND   = 8'd18;
    localparam logic [ADDR_W-1:0] A_THALT   = 8'd20;
    localparam logic [ADDR_W-1:0] A_TCTX    = 8'd21;
    localparam logic [ADDR_W-1:0] A_PSTAT   = 8'd96;
    localparam logic [ADDR_W-1:0] A_XBASE   = 8'd121;
    localparam logic [ADDR_W-1:0] A_CFGA    = 8'd128;
    localparam logic [ADDR_W-1:0] A_CFGB    = 8'd129;
    localparam logic [ADDR_W-1:0] A_CFGC    = 8'd130;
    localparam logic [ADDR_W-1:0] A_CFGD    = 8'd131;
    localparam logic [ADDR_W-1:0] A_LLADDR  = 8'd136;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 8'd250;

    // field positions
    localparam int MTCFG_TC_LO  = 0;
    localparam int MTCFG_VP_LO  = 10;
    localparam int MTCFG_ALLOC  = 15;
    localparam int BIND_VP_LO   = 0;
    localparam int BIND_TC_LO   = 21;
    localparam int TSTAT_ACT    = 15;
    localparam int TSTAT_DYN    = 7;
    localparam int HALT_BIT     = 0;
    localparam int CFG_CONT     = 31;
    localparam int CFGD_MT      = 2;
    localparam int VCFG0_MASTER = 1;

    function automatic reg_loc_t locate(input logic [ADDR_W-1:0] a);
        reg_loc_t r;
        r = '{hit: 1'b1, bank: BK_SHARED, slot: '0};
        case (a)
            A_MTCTL:   r.slot = SLOT_W'(SS_MTCTL);
            A_MTCFG:   r.slot = SLOT_W'(SS_MTCFG);
            A_CFGA:    r.slot = SLOT_W'(SS_CFGA);
            A_CFGB:    r.slot = SLOT_W'(SS_CFGB);
            A_CFGC:    r.slot = SLOT_W'(SS_CFGC);
            A_CFGD:    r.slot = SLOT_W'(SS_CFGD);
            A_SCRATCH: r.slot = SLOT_W'(SS_SCRATCH);
            A_TSTAT:   begin r.bank = BK_THREAD; r.slot = SLOT_W'(TS_STATUS); end
            A_TBIND:   begin r.bank = BK_THREAD; r.slot = SLOT_W'(TS_BIND);   end
            A_THALT:   begin r.bank = BK_THREAD; r.slot = SLOT_W'(TS_HALT);   end
            A_TCTX:    begin r.bank = BK_THREAD; r.slot = SLOT_W'(TS_CTX);    end
            A_PSTAT:   begin r.bank = BK_THREAD; r.slot = SLOT_W'(TS_PSTAT);  end
            A_LLADDR:  begin r.bank = BK_THREAD; r.slot = SLOT_W'(TS_LLADDR); end
            A_VCTL:    begin r.bank = BK_VPROC;  r.slot = SLOT_W'(VS_CTL);    end
            A_VCFG0:   begin r.bank = BK_VPROC;  r.slot = SLOT_W'(VS_CFG0);   end
            A_VCFG1:   begin r.bank = BK_VPROC;  r.slot = SLOT_W'(VS_CFG1);   end
            A_YMASK:   begin r.bank = BK_VPROC;  r.slot = SLOT_W'(VS_YMASK);  end
            A_VSCHED:  begin r.bank = BK_VPROC;  r.slot = SLOT_W'(VS_SCHED);  end
            A_XBASE:   begin r.bank = BK_VPROC;  r.slot = SLOT_W'(VS_XBASE);  end
            default:   begin r.hit = 1'b0; r.bank = BK_NONE; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mtcr_addr_dec.sv
`timescale 1ns/1ps
module mtcr_addr_dec
    import mtcr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_loc_t          loc
);
    always_comb begin
        loc = locate(addr);
    end
endmodule

// File: rtl/mtcr_bank_store.sv
`timescale 1ns/1ps
module mtcr_bank_store
    import mtcr_pkg::*;
#(
    parameter int N_THREADS = 4,
    parameter int N_VPES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  reg_loc_t             wr_loc,
    input  logic [$clog2(N_THREADS)-1:0] wr_tid,
    input  logic [DATA_W-1:0]    wr_data,
    input  reg_loc_t             rd_loc,
    input  logic [$clog2(N_THREADS)-1:0] rd_tid,
    output logic [DATA_W-1:0]    rd_data,
    output logic [N_THREADS-1:0] halt_vec,
    output logic [N_THREADS-1:0] act_vec,
    output logic [7:0]           hi_tc
);
    localparam int VP_W = (N_VPES > 1) ? $clog2(N_VPES) : 1;

    logic [DATA_W-1:0] tc_q [N_THREADS][NUM_TC_SLOTS];
    logic [DATA_W-1:0] tc_d [N_THREADS][NUM_TC_SLOTS];
    logic [DATA_W-1:0] vp_q [N_VPES][NUM_VP_SLOTS];
    logic [DATA_W-1:0] vp_d [N_VPES][NUM_VP_SLOTS];
    logic [DATA_W-1:0] sh_q [NUM_SH_SLOTS];
    logic [DATA_W-1:0] sh_d [NUM_SH_SLOTS];

    logic [VPF_W-1:0] wr_vp, rd_vp;

    function automatic logic [DATA_W-1:0] tc_init(input int t, input int s);
        logic [DATA_W-1:0] v;
        v = '0;
        if (s == TS_BIND)   v[BIND_TC_LO +: 8] = 8'(t);
        if (s == TS_STATUS) begin
            v[TSTAT_DYN] = 1'b1;
            v[TSTAT_ACT] = (t == 0);
        end
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] vp_init(input int p, input int s);
        logic [DATA_W-1:0] v;
        v = '0;
        if (s == VS_CFG0 && p == 0) v[VCFG0_MASTER] = 1'b1;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] sh_init(input int s);
        logic [DATA_W-1:0] v;
        v = '0;
        if (s == SS_CFGA || s == SS_CFGB || s == SS_CFGC) v[CFG_CONT] = 1'b1;
        if (s == SS_CFGD) v[CFGD_MT] = 1'b1;
        if (s == SS_MTCFG) begin
            v[MTCFG_ALLOC]           = 1'b1;
            v[MTCFG_VP_LO +: VPF_W]  = VPF_W'(N_VPES - 1);
            v[MTCFG_TC_LO +: 8]      = 8'(N_THREADS - 1);
        end
        return v;
    endfunction

    always_comb begin
        wr_vp = tc_q[wr_tid][TS_BIND][BIND_VP_LO +: VPF_W];
        rd_vp = tc_q[rd_tid][TS_BIND][BIND_VP_LO +: VPF_W];
    end

    // next state
    always_comb begin
        tc_d = tc_q;
        vp_d = vp_q;
        sh_d = sh_q;
        if (wr_en && wr_loc.hit) begin
            case (wr_loc.bank)
                BK_THREAD: tc_d[wr_tid][wr_loc.slot] = wr_data;
                BK_VPROC:  if (wr_vp < VPF_W'(N_VPES)) vp_d[wr_vp[VP_W-1:0]][wr_loc.slot] = wr_data;
                BK_SHARED: sh_d[wr_loc.slot] = wr_data;
                default:   ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        if (rd_loc.hit) begin
            case (rd_loc.bank)
                BK_THREAD: rd_data = tc_q[rd_tid][rd_loc.slot];
                BK_VPROC:  if (rd_vp < VPF_W'(N_VPES)) rd_data = vp_q[rd_vp[VP_W-1:0]][rd_loc.slot];
                BK_SHARED: rd_data = sh_q[rd_loc.slot];
                default:   rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < N_THREADS; t++)
                for (int s = 0; s < NUM_TC_SLOTS; s++) tc_q[t][s] <= tc_init(t, s);
            for (int p = 0; p < N_VPES; p++)
                for (int s = 0; s < NUM_VP_SLOTS; s++) vp_q[p][s] <= vp_init(p, s);
            for (int s = 0; s < NUM_SH_SLOTS; s++) sh_q[s] <= sh_init(s);
        end else begin
            tc_q <= tc_d;
            vp_q <= vp_d;
            sh_q <= sh_d;
        end
    end

    for (genvar g = 0; g < N_THREADS; g++) begin : g_thr
        assign halt_vec[g] = tc_q[g][TS_HALT][HALT_BIT];
        assign act_vec[g]  = tc_q[g][TS_STATUS][TSTAT_ACT];
    end
    assign hi_tc = sh_q[SS_MTCFG][MTCFG_TC_LO +: 8];

    // R1
    unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_loc.hit |-> rd_data == '0);

    // R3
    bad_vproc_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_loc.bank == BK_VPROC && rd_vp >= VPF_W'(N_VPES)) |-> rd_data == '0);

endmodule

// File: rtl/mtcr_run_eval.sv
`timescale 1ns/1ps
module mtcr_run_eval
    import mtcr_pkg::*;
#(
    parameter int N_THREADS  = 4,
    parameter int EVAL_DELAY = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig,
    input  logic [N_THREADS-1:0] halt_vec,
    input  logic [N_THREADS-1:0] act_vec,
    input  logic [7:0]           hi_tc,
    output logic [N_THREADS-1:0] run_en,
    output logic                 done,
    output logic                 pending
);
    localparam int TID_W = $clog2(N_THREADS);
    localparam int DLY_W = (EVAL_DELAY > 0) ? $clog2(EVAL_DELAY + 1) : 1;

    typedef struct packed {
        phase_e               phase;
        logic [DLY_W-1:0]     cnt;
        logic [TID_W-1:0]     idx;
        logic [N_THREADS-1:0] shadow;
        logic [N_THREADS-1:0] run;
        logic                 done;
    } ev_t;

    ev_t q, d;
    logic [TID_W-1:0] last_idx;

    always_comb begin
        last_idx = (hi_tc >= 8'(N_THREADS - 1)) ? TID_W'(N_THREADS - 1) : hi_tc[TID_W-1:0];
        d = q;
        d.done = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (trig) begin
                    d.shadow = q.run;
                    d.idx    = '0;
                    if (EVAL_DELAY == 0) begin
                        d.phase = PH_WALK;
                    end else begin
                        d.phase = PH_WAIT;
                        d.cnt   = DLY_W'(EVAL_DELAY);
                    end
                end
            end
            PH_WAIT: begin
                if (q.cnt == DLY_W'(1)) d.phase = PH_WALK;
                else                    d.cnt   = q.cnt - DLY_W'(1);
            end
            PH_WALK: begin
                d.shadow[q.idx] = act_vec[q.idx] & ~halt_vec[q.idx];
                if (q.idx == last_idx) begin
                    d.run   = d.shadow;
                    d.done  = 1'b1;
                    d.phase = PH_IDLE;
                end else begin
                    d.idx = q.idx + TID_W'(1);
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase  <= PH_IDLE;
            q.cnt    <= '0;
            q.idx    <= '0;
            q.shadow <= '0;
            q.run    <= N_THREADS'(1);
            q.done   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign run_en  = q.run;
    assign done    = q.done;
    assign pending = (q.phase != PH_IDLE);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R8
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.done |-> $stable(q.run));

    // R9
    eval_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE && trig) |=> q.phase != PH_IDLE);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE && !trig) |=> (q.phase == PH_IDLE && !q.done));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != PH_IDLE) |=> !(q.phase == PH_WAIT && q.cnt == DLY_W'(EVAL_DELAY)));

endmodule

// File: rtl/mt_cregs.sv
`timescale 1ns/1ps
module mt_cregs
    import mtcr_pkg::*;
#(
    parameter int N_THREADS  = 4,
    parameter int N_VPES     = 2,
    parameter int EVAL_DELAY = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_effect,
    input  logic [7:0]                   wr_addr,
    input  logic [$clog2(N_THREADS)-1:0] wr_tid,
    input  logic [31:0]                  wr_data,
    input  logic [7:0]                   rd_addr,
    input  logic [$clog2(N_THREADS)-1:0] rd_tid,
    output logic [31:0]                  rd_data,
    output logic [N_THREADS-1:0]         run_en,
    output logic                         eval_done,
    output logic                         eval_pending
);
    reg_loc_t wr_loc, rd_loc;
    logic [N_THREADS-1:0] halt_vec, act_vec;
    logic [7:0] hi_tc;

    mtcr_addr_dec u_wdec (.addr(wr_addr), .loc(wr_loc));
    mtcr_addr_dec u_rdec (.addr(rd_addr), .loc(rd_loc));

    mtcr_bank_store #(.N_THREADS(N_THREADS), .N_VPES(N_VPES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_loc(wr_loc), .wr_tid(wr_tid), .wr_data(wr_data),
        .rd_loc(rd_loc), .rd_tid(rd_tid), .rd_data(rd_data),
        .halt_vec(halt_vec), .act_vec(act_vec), .hi_tc(hi_tc)
    );

    mtcr_run_eval #(.N_THREADS(N_THREADS), .EVAL_DELAY(EVAL_DELAY)) u_eval (
        .clk(clk), .rst_n(rst_n),
        .trig(wr_en & wr_effect),
        .halt_vec(halt_vec), .act_vec(act_vec), .hi_tc(hi_tc),
        .run_en(run_en), .done(eval_done), .pending(eval_pending)
    );
endmodule

// File: tb/mt_cregs_tb.sv
`timescale 1ns/1ps
module mt_cregs_tb;
    localparam int NT = 4, NV = 2, DLY = 3;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, wr_effect = 0;
    logic [7:0] wr_addr = 0, rd_addr = 0;
    logic [1:0] wr_tid = 0, rd_tid = 0;
    logic [31:0] wr_data = 0, rd_data;
    logic [NT-1:0] run_en;
    logic eval_done, eval_pending;

    mt_cregs #(.N_THREADS(NT), .N_VPES(NV), .EVAL_DELAY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_effect(wr_effect),
        .wr_addr(wr_addr), .wr_tid(wr_tid), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_tid(rd_tid), .rd_data(rd_data),
        .run_en(run_en), .eval_done(eval_done), .eval_pending(eval_pending));

    always #2 clk = ~clk;

    int n_tests = 0, n_fail = 0, cyc = 0, drv_cyc = 0;
    bit finished = 0, prev_done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { logic [NT-1:0] run; int at; } exp_t;
    exp_t sb[$];

    // bench model of thread state
    logic bm_act [NT];
    logic bm_halt [NT];
    int   bm_hi = NT - 1;
    logic [NT-1:0] bm_run = 4'b0001;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] t, input logic [31:0] v, input bit eff);
        @(negedge clk);
        wr_en = 1; wr_effect = eff; wr_addr = a; wr_tid = t; wr_data = v;
        drv_cyc = cyc;
        @(negedge clk);
        wr_en = 0; wr_effect = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [1:0] t, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_addr = a; rd_tid = t;
        #1;
        check(rd_data === exp, req, rd_data, exp);
    endtask

    function automatic logic [NT-1:0] model_eval();
        logic [NT-1:0] r;
        int last;
        r = bm_run;
        last = (bm_hi > NT - 1) ? NT - 1 : bm_hi;
        for (int t = 0; t <= last; t++) r[t] = bm_act[t] & ~bm_halt[t];
        return r;
    endfunction

    // driver side: push expected evaluation result
    task automatic expect_eval(input int start_cyc);
        exp_t e;
        int last;
        last = (bm_hi > NT - 1) ? NT - 1 : bm_hi;
        e.run = model_eval();
        e.at  = start_cyc + 1 + DLY + last + 1;
        bm_run = e.run;
        sb.push_back(e);
    endtask

    task automatic wait_idle();
        int k = 0;
        while ((sb.size() != 0 || eval_pending) && k < 100) begin
            @(negedge clk); k++;
        end
        repeat (3) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_done) check(!eval_done, "R12 done width", 32'(eval_done), 0);
            if (eval_done) begin
                if (sb.size() == 0) begin
                    check(0, "R10/R11 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(run_en === e.run, "R8 run_en", 32'(run_en), 32'(e.run));
                    check(cyc == e.at, "R9 done cycle", cyc, e.at);
                end
            end
            prev_done = eval_done;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) begin bm_act[t] = (t == 0); bm_halt[t] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        check(run_en === 4'b0001, "R8 reset run_en", 32'(run_en), 1);
        check(!eval_done && !eval_pending, "R9 reset idle", {eval_done, eval_pending}, 0);
        rd_chk(8'd128, 0, 32'h8000_0000, "R5 cfgA");
        rd_chk(8'd129, 1, 32'h8000_0000, "R5 cfgB");
        rd_chk(8'd130, 2, 32'h8000_0000, "R5 cfgC");
        rd_chk(8'd131, 3, 32'h0000_0004, "R5 cfgD");
        rd_chk(8'd10,  0, 32'h0000_0002, "R5 vcfg0 vp0");
        rd_chk(8'd2,   0, 32'h0000_8403, "R6 mtcfg");
        for (int t = 0; t < NT; t++) begin
            rd_chk(8'd18, 2'(t), 32'(t) << 21, "R7 bind");
            rd_chk(8'd20, 2'(t), 0, "R7 halt");
            rd_chk(8'd17, 2'(t), (t == 0) ? 32'h8080 : 32'h0080, "R7 tstat");
        end
        // R2 thread banking
        wr(8'd21, 1, 32'hAAAA_0001, 0);
        wr(8'd21, 2, 32'hBBBB_0002, 0);
        rd_chk(8'd21, 1, 32'hAAAA_0001, "R2 tctx t1");
        rd_chk(8'd21, 2, 32'hBBBB_0002, "R2 tctx t2");
        rd_chk(8'd21, 0, 0, "R2 tctx t0");
        // R4 shared
        wr(8'd250, 0, 32'h1234_5678, 0);
        rd_chk(8'd250, 3, 32'h1234_5678, "R4 scratch t3");
        // R3 virtual-processor banking
        wr(8'd9, 0, 32'h0000_00C0, 0);
        wr(8'd18, 1, (32'd1 << 21) | 32'd1, 0);
        wr(8'd9, 1, 32'h0000_00C1, 0);
        rd_chk(8'd9, 0, 32'h0000_00C0, "R3 vctl vp0");
        rd_chk(8'd9, 1, 32'h0000_00C1, "R3 vctl vp1");
        rd_chk(8'd9, 2, 32'h0000_00C0, "R3 vctl t2 on vp0");
        rd_chk(8'd10, 1, 0, "R3 vcfg0 vp1");
        wr(8'd18, 3, (32'd3 << 21) | 32'd5, 0);
        wr(8'd9, 3, 32'hDEAD_BEEF, 0);
        rd_chk(8'd9, 3, 0, "R3 bad vp read");
        rd_chk(8'd9, 0, 32'h0000_00C0, "R3 bad vp write dropped");
        rd_chk(8'd9, 1, 32'h0000_00C1, "R3 bad vp write dropped vp1");
        // R1 holes
        wr(8'd3, 0, 32'hFFFF_FFFF, 0);
        rd_chk(8'd3, 0, 0, "R1 hole read");
        rd_chk(8'd2, 0, 32'h0000_8403, "R1 neighbour intact");
        // R11 plain write of thread state
        wr(8'd17, 1, 32'h0000_8000, 0);
        bm_act[1] = 1;
        repeat (15) @(negedge clk);
        check(run_en === 4'b0001 && !eval_pending, "R11 no eval", 32'(run_en), 1);
        // R9/R8 effect write
        wr(8'd21, 0, 32'h0, 1);
        expect_eval(drv_cyc);
        wait_idle();
        // R10 coalesced writes
        wr(8'd20, 0, 32'h1, 1);
        bm_halt[0] = 1;
        expect_eval(drv_cyc);
        wr(8'd17, 2, 32'h0000_8080, 1);
        bm_act[2] = 1;
        sb[0].run = model_eval();
        bm_run = sb[0].run;
        check(eval_pending, "R10 pending held", 32'(eval_pending), 1);
        wait_idle();
        repeat (20) @(negedge clk);
        // R8 walk range limited by highest-thread field
        wr(8'd2, 0, 32'h0000_8401, 0);
        bm_hi = 1;
        wr(8'd17, 3, 32'h0000_8000, 0);
        bm_act[3] = 1;
        wr(8'd20, 1, 32'h1, 0);
        bm_halt[1] = 1;
        wr(8'd250, 0, 32'h0, 1);
        expect_eval(drv_cyc);
        wait_idle();
        check(run_en === 4'b0100, "R8 range result", 32'(run_en), 32'h4);
        check(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule